// File: doc/BRIEF.md
# DMA Channel Request and Reload Controller

This block is the control half of a two-channel DMA engine. Each channel keeps an enable bit, a request-pending flag, two increment-direction bits, a trigger selector (a mode bit and a 4-bit line index) and three loadable values: source address, destination address and count reload. Software reaches all of this through a simple register write port and a combinational read port. Peripheral request lines arrive as a level vector. A rising level on the line a channel currently selects marks that channel as having a request pending. A one-shot software trigger does the same.

When a channel is enabled and has a request pending, and no transfer is in flight, the block offers a transfer to the datapath on a valid/ready start channel. The offer carries the channel number and the channel's working address pointer. The pending flag clears when the datapath accepts the offer. The datapath reports completion with a single-cycle done pulse. On that pulse the serviced channel's counter steps down by one and its pointer steps up by the transfer size. Only one transfer is in flight at a time. A lower-numbered channel wins when both channels are eligible.

Each write that sets the enable bit re-runs the reload of the counter and pointer. A write that moves the trigger selector onto a line that is already high produces a pending request, exactly as a real edge would.

Top module: `dma_ctl_top`

## Requirements
- R1: After reset every register reads 0 and `xfer_valid` is low. Each channel owns an 8-word window at base channel×8. Offsets are: 0 control, 1 select, 2 source address, 3 destination address, 4 count reload, 5 pointer (read-only), 6 counter (read-only). Control bits are: bit0 enable, bit1 pending, bit2 source-increment, bit3 destination-increment.
- R2: A control write with bit0 = 1 loads the counter from the count reload value.
- R3: That same write loads the pointer from the source address when the written bit2 is 1. Otherwise it loads the pointer from the destination address when the written bit3 is 1. Otherwise the pointer keeps its value.
- R4: Writing bit0 = 1 while the channel is already enabled performs the reload again.
- R5: The select register holds the line index in bits 3:0 and the mode in bit4. A channel watches `periph_req[{mode,index}]`. A rising level there sets the pending flag even when the channel is disabled. A disabled channel never offers a transfer.
- R6: Writing the select register with bit5 = 1 raises a request once. Bit5 always reads back as 0.
- R7: A control write with bit1 = 0 clears the pending flag. A control write with bit1 = 1 leaves the flag unchanged.
- R8: An enabled channel with a request pending raises `xfer_valid`, driving its number on `xfer_ch` and its pointer on `xfer_addr`. The offer holds while `xfer_ready` is low. Acceptance clears the pending flag and blocks new offers until `xfer_done`.
- R9: On `xfer_done` the serviced channel's counter decreases by 1 and its pointer increases by STEP (default 2).
- R10: When both channels are eligible, channel 0 is offered first. Channel 1 keeps its pending flag until it is served.
- R11: A select write that moves a channel onto a line already at 1 sets its pending flag one cycle later.
- R12: A control write setting enable in the same cycle as a request event completes its reload and leaves the flag set, so the offer follows with the reloaded pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address: channel×8 + offset |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 16 | Read data (combinational) |
| periph_req | input | 32 | Peripheral request levels |
| xfer_valid | output | 1 | Transfer offer valid |
| xfer_ready | input | 1 | Datapath accepts offer |
| xfer_ch | output | 1 | Channel of the offer |
| xfer_addr | output | 16 | Pointer for the offer |
| xfer_done | input | 1 | Transfer finished pulse |

## Verification
The bench checks that a request on a disabled channel still leaves a flag behind. A design that gated latching with enable would lose it. It moves a selector onto a line that is already high. A design that sampled the old line's history wrongly would either miss the false request or raise it on the wrong channel. It makes both channels eligible at once to catch a lost loser flag or inverted priority. It also lands a request in the same cycle as an enabling write, which a design that let the reload clear the flag would drop.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int IDX_W = 4;
  localparam int SEL_W = IDX_W + 1;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_PEND = 1;
  localparam int CTRL_SINC = 2;
  localparam int CTRL_DINC = 3;
  localparam int SEL_SWT   = 5;

  typedef enum logic [2:0] {
    OFF_CTRL = 3'd0,
    OFF_SEL  = 3'd1,
    OFF_SRC  = 3'd2,
    OFF_DST  = 3'd3,
    OFF_RLD  = 3'd4,
    OFF_PTR  = 3'd5,
    OFF_CNT  = 3'd6,
    OFF_RSV  = 3'd7
  } reg_off_e;
endpackage

// File: rtl/dma_req_edge.sv
module dma_req_edge #(
  parameter int SEL_W  = 5,
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lines,
  input  logic [SEL_W-1:0]  sel,
  input  logic              swt,
  output logic              evt
);
  logic lvl, lvl_q;

  // level of the currently selected line; the history follows the selection,
  // so moving onto a high line looks like an edge
  assign lvl = lines[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign evt = (lvl & ~lvl_q) | swt;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_ctl_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_sel,
  input  logic             wr_src,
  input  logic             wr_dst,
  input  logic             wr_rld,
  input  logic [DW-1:0]    wdata,
  input  logic             req_evt,
  input  logic             start_acc,
  input  logic             xfer_end,
  output logic             en_o,
  output logic             pend_o,
  output logic             sinc_o,
  output logic             dinc_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [AW-1:0]    ptr_o,
  output logic [CW-1:0]    rld_o,
  output logic [CW-1:0]    cnt_o
);
  logic en_q, pend_q, sinc_q, dinc_q;
  logic [SEL_W-1:0] sel_q;
  logic [AW-1:0] src_q, dst_q, ptr_q;
  logic [CW-1:0] rld_q, cnt_q;
  logic do_reload;

  assign do_reload = wr_ctrl && wdata[CTRL_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
      sel_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      rld_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata[CTRL_EN];
        sinc_q <= wdata[CTRL_SINC];
        dinc_q <= wdata[CTRL_DINC];
      end
      if (wr_sel) sel_q <= wdata[SEL_W-1:0];
      if (wr_src) src_q <= wdata[AW-1:0];
      if (wr_dst) dst_q <= wdata[AW-1:0];
      if (wr_rld) rld_q <= wdata[CW-1:0];
    end
  end

  // pending: a hardware event wins over any clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               pend_q <= 1'b0;
    else if (req_evt)                         pend_q <= 1'b1;
    else if (wr_ctrl && !wdata[CTRL_PEND])    pend_q <= 1'b0;
    else if (start_acc)                       pend_q <= 1'b0;
  end

  // reload on enable write takes priority over a completing transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (do_reload) begin
      cnt_q <= rld_q;
      if (wdata[CTRL_SINC])      ptr_q <= src_q;
      else if (wdata[CTRL_DINC]) ptr_q <= dst_q;
    end else if (xfer_end) begin
      cnt_q <= cnt_q - CW'(1);
      ptr_q <= ptr_q + AW'(STEP);
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign sinc_o = sinc_q;
  assign dinc_o = dinc_q;
  assign sel_o  = sel_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign ptr_o  = ptr_q;
  assign rld_o  = rld_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/dma_fixed_arb.sv
module dma_fixed_arb #(
  parameter int N    = 2,
  parameter int IX_W = 1
) (
  input  logic [N-1:0]    req,
  input  logic            busy,
  output logic            vld,
  output logic [IX_W-1:0] idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = IX_W'(i);
      end
    end
    if (busy) vld = 1'b0;
  end
endmodule

// File: rtl/dma_ctl_top.sv
module dma_ctl_top
  import dma_ctl_pkg::*;
#(
  parameter  int NCH    = 2,
  parameter  int DW     = 16,
  parameter  int AW     = 16,
  parameter  int CW     = 16,
  parameter  int STEP   = 2,
  localparam int NLINES = 2 ** SEL_W,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RA_W   = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_waddr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [RA_W-1:0]   reg_raddr,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NLINES-1:0] periph_req,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [CH_W-1:0]   xfer_ch,
  output logic [AW-1:0]     xfer_addr,
  input  logic              xfer_done
);
  logic [CH_W-1:0] wch, rch;
  reg_off_e        woff, roff;

  logic [NCH-1:0]            en_v, pend_v, sinc_v, dinc_v;
  logic [NCH-1:0][SEL_W-1:0] sel_v;
  logic [NCH-1:0][AW-1:0]    src_v, dst_v, ptr_v;
  logic [NCH-1:0][CW-1:0]    rld_v, cnt_v;

  logic            busy_q;
  logic [CH_W-1:0] cur_q;
  logic            gnt_vld;
  logic [CH_W-1:0] gnt_idx;
  logic            accept;

  assign wch  = reg_waddr[RA_W-1:3];
  assign woff = reg_off_e'(reg_waddr[2:0]);
  assign rch  = reg_raddr[RA_W-1:3];
  assign roff = reg_off_e'(reg_raddr[2:0]);

  assign accept = xfer_valid && xfer_ready;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit, evt, swt;
    assign hit = reg_we && (wch == CH_W'(c));
    assign swt = hit && (woff == OFF_SEL) && reg_wdata[SEL_SWT];

    dma_req_edge #(.SEL_W(SEL_W), .NLINES(NLINES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (periph_req),
      .sel   (sel_v[c]),
      .swt   (swt),
      .evt   (evt)
    );

    dma_chan_regs #(.DW(DW), .AW(AW), .CW(CW), .STEP(STEP)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (hit && (woff == OFF_CTRL)),
      .wr_sel    (hit && (woff == OFF_SEL)),
      .wr_src    (hit && (woff == OFF_SRC)),
      .wr_dst    (hit && (woff == OFF_DST)),
      .wr_rld    (hit && (woff == OFF_RLD)),
      .wdata     (reg_wdata),
      .req_evt   (evt),
      .start_acc (accept && (xfer_ch == CH_W'(c))),
      .xfer_end  (xfer_done && busy_q && (cur_q == CH_W'(c))),
      .en_o      (en_v[c]),
      .pend_o    (pend_v[c]),
      .sinc_o    (sinc_v[c]),
      .dinc_o    (dinc_v[c]),
      .sel_o     (sel_v[c]),
      .src_o     (src_v[c]),
      .dst_o     (dst_v[c]),
      .ptr_o     (ptr_v[c]),
      .rld_o     (rld_v[c]),
      .cnt_o     (cnt_v[c])
    );
  end

  dma_fixed_arb #(.N(NCH), .IX_W(CH_W)) u_arb (
    .req  (en_v & pend_v),
    .busy (busy_q),
    .vld  (gnt_vld),
    .idx  (gnt_idx)
  );

  assign xfer_valid = gnt_vld;
  assign xfer_ch    = gnt_idx;
  assign xfer_addr  = ptr_v[gnt_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cur_q  <= gnt_idx;
    end else if (xfer_done) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (roff)
      OFF_CTRL: reg_rdata[3:0] = {dinc_v[rch], sinc_v[rch], pend_v[rch], en_v[rch]};
      OFF_SEL:  reg_rdata[SEL_W-1:0] = sel_v[rch];
      OFF_SRC:  reg_rdata[AW-1:0] = src_v[rch];
      OFF_DST:  reg_rdata[AW-1:0] = dst_v[rch];
      OFF_RLD:  reg_rdata[CW-1:0] = rld_v[rch];
      OFF_PTR:  reg_rdata[AW-1:0] = ptr_v[rch];
      OFF_CNT:  reg_rdata[CW-1:0] = cnt_v[rch];
      OFF_RSV:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk #(
  parameter  int NCH  = 2,
  parameter  int CW   = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RA_W = CH_W + 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_we,
  input logic [RA_W-1:0]        reg_waddr,
  input logic                   w_en_bit,
  input logic                   w_pend_bit,
  input logic                   xfer_valid,
  input logic                   xfer_ready,
  input logic [CH_W-1:0]        xfer_ch,
  input logic                   xfer_done,
  input logic [NCH-1:0]         en,
  input logic [NCH-1:0]         pend,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [NCH-1:0][CW-1:0] rld,
  input logic                   busy,
  input logic [CH_W-1:0]        cur
);
  // R8
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready && !reg_we) |=> xfer_valid);

  // R8
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> !xfer_valid);

  // R10
  low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && en[0] && pend[0]) |-> (xfer_ch == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_waddr == RA_W'(c * 8));

    // R2
    reload_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && w_en_bit) |=> (cnt[c] == $past(rld[c])));

    // R9
    done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && busy && (cur == CH_W'(c)) && !ctrl_wr) |=> (cnt[c] == $past(cnt[c]) - CW'(1)));

    // R7
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[c] && !(ctrl_wr && !w_pend_bit) && !(xfer_valid && xfer_ready && xfer_ch == CH_W'(c)))
        |=> pend[c]);
  end
endmodule

bind dma_ctl_top dma_ctl_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_waddr  (reg_waddr),
  .w_en_bit   (reg_wdata[0]),
  .w_pend_bit (reg_wdata[1]),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_ch    (xfer_ch),
  .xfer_done  (xfer_done),
  .en         (en_v),
  .pend       (pend_v),
  .cnt        (cnt_v),
  .rld        (rld_v),
  .busy       (busy_q),
  .cur        (cur_q)
);

// File: tb/sim_dma_ctl_top.sv
`timescale 1ns/1ps
module sim_dma_ctl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [15:0] reg_rdata;
  logic [31:0] periph_req = '0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [0:0]  xfer_ch;
  logic [15:0] xfer_addr;
  logic        xfer_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_ctl_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .periph_req(periph_req), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_ch(xfer_ch), .xfer_addr(xfer_addr), .xfer_done(xfer_done)
  );

  // vector: op[25:24] (0 write, 1 read-compare), addr[23:20], data[19:4], req[3:0]
  localparam int NV = 19;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 4'h2, 16'h1000, 4'd3},
    {2'd0, 4'h3, 16'h2000, 4'd3},
    {2'd0, 4'h4, 16'h0005, 4'd2},
    {2'd0, 4'h0, 16'h0005, 4'd2},  // R2 enable with source-increment
    {2'd1, 4'h6, 16'h0005, 4'd2},  // R2 counter reloaded
    {2'd1, 4'h5, 16'h1000, 4'd3},  // R3 pointer from source
    {2'd1, 4'h0, 16'h0005, 4'd1},
    {2'd0, 4'h0, 16'h0009, 4'd3},  // R3 destination-increment
    {2'd1, 4'h5, 16'h2000, 4'd3},  // R3 pointer from destination
    {2'd0, 4'h4, 16'h0007, 4'd4},
    {2'd0, 4'h0, 16'h0009, 4'd4},  // R4 enable again
    {2'd1, 4'h6, 16'h0007, 4'd4},  // R4 reload re-run
    {2'd0, 4'h0, 16'h000B, 4'd7},  // R7 writing pending=1
    {2'd1, 4'h0, 16'h0009, 4'd7},  // R7 no effect
    {2'd0, 4'h1, 16'h0020, 4'd6},  // R6 software trigger
    {2'd1, 4'h0, 16'h000B, 4'd6},  // R6 pending set
    {2'd1, 4'h1, 16'h0000, 4'd6},  // R6 trigger bit reads 0
    {2'd0, 4'h0, 16'h0008, 4'd7},  // R7 write 0 clears
    {2'd1, 4'h0, 16'h0008, 4'd7}
  };

  task automatic check(input int r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rdchk(input int r, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(r, v, exp);
  endtask

  task automatic pulse_line(input int k);
    @(negedge clk); periph_req[k] = 1'b1;
    @(negedge clk); periph_req[k] = 1'b0;
  endtask

  task automatic accept_one();
    @(negedge clk); xfer_ready = 1'b1;
    @(negedge clk); xfer_ready = 1'b0;
  endtask

  task automatic done_one();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdchk(1, 4'h0, 16'h0000);
    rdchk(1, 4'h6, 16'h0000);
    rdchk(1, 4'h8, 16'h0000);
    rdchk(1, 4'h9, 16'h0000);
    check(1, {15'd0, xfer_valid}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25:24] == 2'd0) wr(VEC[i][23:20], VEC[i][19:4]);
      else rdchk(int'(VEC[i][3:0]), VEC[i][23:20], VEC[i][19:4]);
    end

    // R5 request latched while disabled, no offer
    wr(4'h1, 16'h0003);
    pulse_line(3);
    rdchk(5, 4'h0, 16'h000A);
    check(5, {15'd0, xfer_valid}, 16'h0000);
    wr(4'h0, 16'h0008);

    // R11 selector moves onto a line that is already high
    @(negedge clk); periph_req[20] = 1'b1;
    wr(4'h1, 16'h0014);
    @(negedge clk);
    rdchk(11, 4'h0, 16'h000A);
    periph_req[20] = 1'b0;
    wr(4'h0, 16'h0008);
    rdchk(11, 4'h0, 16'h0008);

    // R8 offer, back-pressure, accept; R9 completion
    wr(4'h2, 16'h0100);
    wr(4'h4, 16'h0003);
    wr(4'h0, 16'h0005);
    pulse_line(20);
    check(8, {15'd0, xfer_valid}, 16'h0001);
    check(8, xfer_addr, 16'h0100);
    check(8, {15'd0, xfer_ch}, 16'h0000);
    repeat (2) @(negedge clk);
    check(8, {15'd0, xfer_valid}, 16'h0001);
    rdchk(8, 4'h0, 16'h0007);
    accept_one();
    check(8, {15'd0, xfer_valid}, 16'h0000);
    rdchk(8, 4'h0, 16'h0005);
    done_one();
    rdchk(9, 4'h6, 16'h0002);
    rdchk(9, 4'h5, 16'h0102);

    // R10 both channels at once
    wr(4'hA, 16'h0300);
    wr(4'hC, 16'h0004);
    wr(4'h9, 16'h0007);
    wr(4'h8, 16'h0005);
    @(negedge clk); periph_req[7] = 1'b1; periph_req[20] = 1'b1;
    @(negedge clk); periph_req[7] = 1'b0; periph_req[20] = 1'b0;
    check(10, {15'd0, xfer_ch}, 16'h0000);
    check(10, xfer_addr, 16'h0102);
    accept_one();
    rdchk(10, 4'h8, 16'h0007);
    done_one();
    check(10, {15'd0, xfer_valid}, 16'h0001);
    check(10, {15'd0, xfer_ch}, 16'h0001);
    check(10, xfer_addr, 16'h0300);
    accept_one();
    done_one();
    rdchk(9, 4'hE, 16'h0003);
    rdchk(9, 4'h6, 16'h0001);

    // R12 enabling write and request event in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 4'h0; reg_wdata = 16'h0007;
    periph_req[20] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    check(12, {15'd0, xfer_valid}, 16'h0001);
    check(12, xfer_addr, 16'h0100);
    rdchk(12, 4'h6, 16'h0003);
    rdchk(12, 4'h0, 16'h0007);
    periph_req[20] = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule